// File: doc/BRIEF.md
# 4x4 SAD Processing Element

This block compares one 4x4 block of current-frame pixels with a series of 4x4 candidate blocks from a reference frame. For each candidate it reports a block distortion, the sum of absolute differences (SAD), and it keeps the best candidate of the running search. Pixels are 8-bit unsigned values. Each pixel sits in its own register, and two independent 32-bit load ports fill the registers one row at a time. Each load word holds the four pixels of one row.

Sixteen absolute-difference units feed a two-level adder tree. The first level has four 10-bit row adders. The second level is one 12-bit adder. The tree is combinational from the pixel registers. When a candidate is presented together with its signed 8-bit motion vector, a comparator updates the stored minimum SAD and its motion vector at that clock edge.

The surrounding search controller does the following. It starts a search, reloads the reference registers for each candidate, and flags the last candidate. One cycle after the last candidate it receives a done pulse, with the best SAD and motion vector on the outputs.

Top module: `sad4x4_pe`

## Requirements
- R1: When `cur_we` is high, the edge writes `cur_word` into current row `cur_row`. `ref_we`, `ref_row` and `ref_word` do the same for the reference rows. Byte lane j, bits [8j+7:8j], holds column j, so the leftmost pixel is in bits [7:0]. Other rows are unchanged.
- R2: Current and reference loads are independent and may happen in the same cycle.
- R3: Each pixel pair contributes the unsigned magnitude of its 8-bit difference.
- R4: The candidate SAD is the exact sum of all sixteen differences. Its range is 0 to 4080, and it never wraps in 12 bits.
- R5: `search_start` sets the stored minimum to 4095 and the stored vector to (0,0). A candidate presented in the same cycle is compared against 4095, not against the old minimum.
- R6: A candidate replaces the stored result only if its SAD is strictly lower. Outside of `search_start`, `best_sad` never increases.
- R7: When two candidates have equal SAD, the vector of the earlier candidate is kept.
- R8: `cand_valid` evaluates the pixel registers as they stood before that edge. `best_sad`, `best_mvx` and `best_mvy` show the result in the cycle after `cand_valid`.
- R9: `done` is high for exactly the one cycle after a cycle with both `cand_valid` and `cand_last` high, and low otherwise.
- R10: After reset, `best_sad` is 4095, the vector is (0,0), `done` is 0, and all pixel registers hold 0.
- R11: The best vector outputs return the candidate's two's-complement offsets unchanged, including negative values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| search_start | input | 1 | Begin a new search; clears the stored minimum |
| cur_we | input | 1 | Write one current-block row |
| cur_row | input | 2 | Current row index |
| cur_word | input | 32 | Four current pixels, column 0 in [7:0] |
| ref_we | input | 1 | Write one reference-block row |
| ref_row | input | 2 | Reference row index |
| ref_word | input | 32 | Four reference pixels, column 0 in [7:0] |
| cand_valid | input | 1 | Evaluate the loaded reference block as a candidate |
| cand_last | input | 1 | Marks the final candidate of the search |
| cand_mvx | input | 8 | Signed horizontal offset of the candidate |
| cand_mvy | input | 8 | Signed vertical offset of the candidate |
| best_sad | output | 12 | Lowest SAD seen in the current search |
| best_mvx | output | 8 | Horizontal offset of the best candidate |
| best_mvy | output | 8 | Vertical offset of the best candidate |
| done | output | 1 | One-cycle pulse after the last candidate |

## Verification
A row write takes effect at the edge where its enable is sampled. A candidate's effect on `best_sad`, the vector and `done` appears right after the edge where `cand_valid` is sampled. `done` falls again one edge later. The bench changes inputs on the falling edge and reads outputs on the next falling edge. Each check therefore looks half a cycle after the single register stage it depends on. A further check one cycle later confirms the end of the `done` pulse. For the same-cycle case (reload together with a candidate), the bench reads the result on the very next falling edge, so it must reflect the old register contents.

// File: rtl/sad_pe_pkg.sv
`timescale 1ns/1ps
package sad_pe_pkg;
    localparam int PIX_W    = 8;
    localparam int BLK_ROWS = 4;
    localparam int BLK_COLS = 4;
    localparam int NPIX     = BLK_ROWS * BLK_COLS;
    localparam int ROW_W    = $clog2(BLK_ROWS);
    localparam int WORD_W   = BLK_COLS * PIX_W;
    localparam int PART_W   = PIX_W + $clog2(BLK_COLS);
    localparam int SAD_W    = PART_W + $clog2(BLK_ROWS);
    localparam int MV_W     = 8;

    typedef logic [PIX_W-1:0]          pix_t;
    typedef logic [NPIX-1:0][PIX_W-1:0] blk_t;
    typedef logic [SAD_W-1:0]          sad_t;

    typedef struct packed {
        logic signed [MV_W-1:0] x;
        logic signed [MV_W-1:0] y;
    } mv_t;

    typedef struct packed {
        sad_t sad;
        mv_t  mv;
    } cand_t;

    localparam sad_t SAD_INIT = '1;

    function automatic pix_t pix_mag(input pix_t a, input pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction
endpackage

// File: rtl/sad_pix_bank.sv
`timescale 1ns/1ps
module sad_pix_bank
    import sad_pe_pkg::*;
#(
    parameter int ROWS = BLK_ROWS,
    parameter int COLS = BLK_COLS,
    parameter int PW   = PIX_W,
    localparam int WW  = COLS * PW,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [RW-1:0]                row,
    input  logic [WW-1:0]                word,
    output logic [ROWS*COLS-1:0][PW-1:0] pix
);
    logic [WW-1:0] rows_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows_q[r] <= '0;
            end else if (we && row == RW'(r)) begin
                rows_q[r] <= word;
            end
        end
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign pix[r*COLS+c] = rows_q[r][c*PW +: PW];
        end
    end

    // R1: the addressed row holds the written word one edge later
    a_r1_row_written: assert property (@(posedge clk) disable iff (rst)
        we |=> rows_q[$past(row)] == $past(word));
endmodule

// File: rtl/sad_absdiff_tree.sv
`timescale 1ns/1ps
module sad_absdiff_tree
    import sad_pe_pkg::*;
#(
    parameter int ROWS = BLK_ROWS,
    parameter int COLS = BLK_COLS,
    parameter int PW   = PIX_W,
    localparam int N   = ROWS * COLS,
    localparam int PW1 = PW + $clog2(COLS),
    localparam int SW  = PW1 + $clog2(ROWS)
) (
    input  logic [N-1:0][PW-1:0] cur_pix,
    input  logic [N-1:0][PW-1:0] ref_pix,
    output logic [SW-1:0]        sad
);
    logic [PW-1:0]  mag  [N];
    logic [PW1-1:0] part [ROWS];

    for (genvar i = 0; i < N; i++) begin : g_mag
        assign mag[i] = (cur_pix[i] > ref_pix[i]) ? (cur_pix[i] - ref_pix[i])
                                                  : (ref_pix[i] - cur_pix[i]);
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_part
        logic [PW1-1:0] acc;
        always_comb begin
            acc = '0;
            for (int c = 0; c < COLS; c++) begin
                acc = acc + PW1'(mag[r*COLS+c]);
            end
        end
        assign part[r] = acc;
    end

    always_comb begin
        sad = '0;
        for (int r = 0; r < ROWS; r++) begin
            sad = sad + SW'(part[r]);
        end
    end
endmodule

// File: rtl/sad_best_tracker.sv
`timescale 1ns/1ps
module sad_best_tracker
    import sad_pe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  search_start,
    input  logic  cand_valid,
    input  logic  cand_last,
    input  cand_t cand,
    output sad_t  best_sad,
    output mv_t   best_mv,
    output logic  done
);
    sad_t bar;
    logic take;

    assign bar  = search_start ? SAD_INIT : best_sad;
    assign take = cand_valid && (cand.sad < bar);

    always_ff @(posedge clk) begin
        if (rst) begin
            best_sad <= SAD_INIT;
            best_mv  <= '0;
            done     <= 1'b0;
        end else begin
            done <= cand_valid && cand_last;
            if (take) begin
                best_sad <= cand.sad;
                best_mv  <= cand.mv;
            end else if (search_start) begin
                best_sad <= SAD_INIT;
                best_mv  <= '0;
            end
        end
    end

    // R6: the minimum only falls within a search
    a_r6_never_rises: assert property (@(posedge clk) disable iff (rst)
        !search_start |=> best_sad <= $past(best_sad));

    // R5: a start with no candidate leaves the cleared state
    a_r5_start_clears: assert property (@(posedge clk) disable iff (rst)
        (search_start && !cand_valid) |=> (best_sad == SAD_INIT && best_mv == '0));

    // R7: an equal SAD keeps the earlier vector
    a_r7_tie_keeps: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && !search_start && cand.sad == best_sad) |=> best_mv == $past(best_mv));

    // R9: done follows the last candidate by one cycle
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (cand_valid && cand_last) |=> done);

    // R9: done stays low otherwise
    a_r9_done_only_then: assert property (@(posedge clk) disable iff (rst)
        !(cand_valid && cand_last) |=> !done);
endmodule

// File: rtl/sad4x4_pe.sv
`timescale 1ns/1ps
module sad4x4_pe
    import sad_pe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              search_start,
    input  logic              cur_we,
    input  logic [ROW_W-1:0]  cur_row,
    input  logic [WORD_W-1:0] cur_word,
    input  logic              ref_we,
    input  logic [ROW_W-1:0]  ref_row,
    input  logic [WORD_W-1:0] ref_word,
    input  logic              cand_valid,
    input  logic              cand_last,
    input  logic [MV_W-1:0]   cand_mvx,
    input  logic [MV_W-1:0]   cand_mvy,
    output logic [SAD_W-1:0]  best_sad,
    output logic [MV_W-1:0]   best_mvx,
    output logic [MV_W-1:0]   best_mvy,
    output logic              done
);
    blk_t  cur_pix, ref_pix;
    sad_t  cand_sad;
    cand_t cand;
    mv_t   best_mv;

    sad_pix_bank u_cur_bank (
        .clk (clk), .rst (rst), .we (cur_we), .row (cur_row),
        .word(cur_word), .pix (cur_pix)
    );

    sad_pix_bank u_ref_bank (
        .clk (clk), .rst (rst), .we (ref_we), .row (ref_row),
        .word(ref_word), .pix (ref_pix)
    );

    sad_absdiff_tree u_tree (
        .cur_pix(cur_pix), .ref_pix(ref_pix), .sad(cand_sad)
    );

    assign cand.sad  = cand_sad;
    assign cand.mv.x = cand_mvx;
    assign cand.mv.y = cand_mvy;

    sad_best_tracker u_best (
        .clk         (clk),
        .rst         (rst),
        .search_start(search_start),
        .cand_valid  (cand_valid),
        .cand_last   (cand_last),
        .cand        (cand),
        .best_sad    (best_sad),
        .best_mv     (best_mv),
        .done        (done)
    );

    assign best_mvx = best_mv.x;
    assign best_mvy = best_mv.y;
endmodule

// File: tb/test_sad4x4_pe.sv
`timescale 1ns/1ps
module test_sad4x4_pe;
    logic        clk = 1'b0;
    logic        rst;
    logic        search_start, cur_we, ref_we, cand_valid, cand_last;
    logic [1:0]  cur_row, ref_row;
    logic [31:0] cur_word, ref_word;
    logic [7:0]  cand_mvx, cand_mvy;
    logic [11:0] best_sad;
    logic [7:0]  best_mvx, best_mvy;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] cur_m [16];
    logic [7:0] ref_m [16];

    always #2.5 clk = ~clk;

    sad4x4_pe i_sad4x4_pe (
        .clk(clk), .rst(rst), .search_start(search_start),
        .cur_we(cur_we), .cur_row(cur_row), .cur_word(cur_word),
        .ref_we(ref_we), .ref_row(ref_row), .ref_word(ref_word),
        .cand_valid(cand_valid), .cand_last(cand_last),
        .cand_mvx(cand_mvx), .cand_mvy(cand_mvy),
        .best_sad(best_sad), .best_mvx(best_mvx), .best_mvy(best_mvy),
        .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_sad();
        int s = 0;
        for (int i = 0; i < 16; i++)
            s += (cur_m[i] > ref_m[i]) ? int'(cur_m[i]) - int'(ref_m[i])
                                       : int'(ref_m[i]) - int'(cur_m[i]);
        return s;
    endfunction

    task automatic load_blocks(input bit do_cur, input bit do_ref);
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            cur_we   = do_cur;
            ref_we   = do_ref;
            cur_row  = r[1:0];
            ref_row  = r[1:0];
            cur_word = {cur_m[r*4+3], cur_m[r*4+2], cur_m[r*4+1], cur_m[r*4]};
            ref_word = {ref_m[r*4+3], ref_m[r*4+2], ref_m[r*4+1], ref_m[r*4]};
        end
        @(negedge clk);
        cur_we = 1'b0;
        ref_we = 1'b0;
    endtask

    task automatic eval(input int mx, input int my, input bit st, input bit la);
        @(negedge clk);
        cand_valid   = 1'b1;
        search_start = st;
        cand_last    = la;
        cand_mvx     = mx[7:0];
        cand_mvy     = my[7:0];
        @(negedge clk);
        cand_valid   = 1'b0;
        search_start = 1'b0;
        cand_last    = 1'b0;
    endtask

    task automatic fill(input int cv, input int rv);
        for (int i = 0; i < 16; i++) begin
            cur_m[i] = cv[7:0];
            ref_m[i] = rv[7:0];
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int best, bx, by, s;
        rst = 1'b1;
        search_start = 0; cur_we = 0; ref_we = 0; cand_valid = 0; cand_last = 0;
        cur_row = 0; ref_row = 0; cur_word = 0; ref_word = 0; cand_mvx = 0; cand_mvy = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk("R10 best_sad", best_sad, 4095);
        chk("R10 mvx", best_mvx, 0);
        chk("R10 mvy", best_mvy, 0);
        chk("R10 done", done, 0);
        eval(3, 4, 1, 1);
        chk("R10 pixels zero", best_sad, 0);
        chk("R9 done pulse", done, 1);
        @(negedge clk);
        chk("R9 done falls", done, 0);

        // R1/R2: position sweep, one marked pixel per block, both loaded together
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                fill(0, 0);
                cur_m[p] = 8'd255;
                ref_m[q] = 8'd255;
                load_blocks(1, 1);
                eval(p, -q, 1, 1);
                chk($sformatf("R1 R2 pos p=%0d q=%0d", p, q), best_sad, (p == q) ? 0 : 510);
                chk("R11 mvy negative", $signed(best_mvy), -q);
            end
        end

        // R3/R4: uniform blocks across the value range, including 4080
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 17) begin
                fill(a, b);
                load_blocks(1, 1);
                eval(0, 0, 1, 1);
                chk($sformatf("R3 R4 a=%0d b=%0d", a, b), best_sad, 16 * ((a > b) ? a - b : b - a));
            end
        end

        // R3: distinct pixels, mixed signs of difference
        for (int i = 0; i < 16; i++) begin
            cur_m[i] = 8'(i * 16);
            ref_m[i] = 8'(255 - i * 13);
        end
        load_blocks(1, 1);
        eval(1, 1, 1, 1);
        chk("R3 mixed", best_sad, model_sad());

        // R6/R11: a search of twenty candidates over one current block
        for (int i = 0; i < 16; i++) cur_m[i] = 8'(i * 29 + 7);
        load_blocks(1, 0);
        best = 4095; bx = 0; by = 0;
        for (int k = 0; k < 20; k++) begin
            for (int i = 0; i < 16; i++) ref_m[i] = 8'((k * 37 + i * 11 + k * i) % 256);
            load_blocks(0, 1);
            s = model_sad();
            if (s < best) begin best = s; bx = k - 10; by = 7 - 3 * k; end
            eval(k - 10, 7 - 3 * k, k == 0, k == 19);
            chk($sformatf("R6 search k=%0d sad", k), best_sad, best);
            chk("R11 mvx", $signed(best_mvx), bx);
            chk("R11 mvy", $signed(best_mvy), by);
            chk("R9 done", done, (k == 19) ? 1 : 0);
        end
        @(negedge clk);
        chk("R9 done one cycle", done, 0);

        // R7: equal SAD keeps the earlier vector
        fill(20, 30);
        load_blocks(1, 1);
        eval(1, 1, 1, 0);
        eval(2, 2, 0, 0);
        chk("R7 tie sad", best_sad, 160);
        chk("R7 tie mvx", best_mvx, 1);
        chk("R7 tie mvy", best_mvy, 1);
        fill(20, 25);
        load_blocks(0, 1);
        eval(-5, 6, 0, 1);
        chk("R6 lower replaces", best_sad, 80);
        chk("R6 lower mvx", $signed(best_mvx), -5);

        // R5: start alone clears; start with a worse candidate still takes it
        @(negedge clk);
        search_start = 1'b1;
        @(negedge clk);
        search_start = 1'b0;
        chk("R5 cleared sad", best_sad, 4095);
        chk("R5 cleared mvx", best_mvx, 0);
        fill(0, 100);
        load_blocks(1, 1);
        eval(4, 4, 1, 0);
        chk("R5 compare vs all ones", best_sad, 1600);
        fill(0, 120);
        load_blocks(0, 1);
        eval(9, 9, 1, 1);
        chk("R5 start with worse candidate", best_sad, 1920);
        chk("R5 start mvx", best_mvx, 9);

        // R8: reload in the same cycle as a candidate uses old contents
        fill(0, 10);
        load_blocks(1, 1);
        @(negedge clk);
        ref_we = 1'b1; ref_row = 2'd0; ref_word = 32'h32323232;
        cand_valid = 1'b1; search_start = 1'b1; cand_last = 1'b1;
        cand_mvx = 8'd1; cand_mvy = 8'd2;
        @(negedge clk);
        ref_we = 1'b0; cand_valid = 1'b0; search_start = 1'b0; cand_last = 1'b0;
        chk("R8 old contents", best_sad, 160);
        for (int i = 0; i < 4; i++) ref_m[i] = 8'd50;
        eval(0, 0, 1, 1);
        chk("R8 new contents", best_sad, model_sad());

        finish_run();
    end
endmodule